// File: doc/BRIEF.md
# Software Interrupt Entry Sequencer

This block carries out the entry steps of a software break for an 8-bit processor whose stack lives in page one of memory and grows downward. When the core raises a trigger, the block takes a snapshot of the current program counter, the current status byte and the 16-bit handler vector. It then writes a three-byte return frame to the stack through a byte-wide memory write port, one byte per clock. Once the frame is written, it loads the program counter with the vector and sets the interrupt-disable flag.

The stack pointer is held inside the block. Each frame write goes to page one at the current pointer value, and the pointer then moves down by one, wrapping modulo 256. The status copy written to the stack has its break bit forced high. The live status result takes its other bits from the snapshot and also has interrupt-disable set. A trigger is taken only while the block is idle. A whole entry takes four cycles after the trigger, and `busy_o` is high for all four.

Top module: `brk_entry_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `sp_o` = 0xFF, `pc_o` = 0x0000, `flags_o` = 0x00, and `busy_o` and `mem_we_o` are both 0.
- R2: A trigger taken while idle is followed, in the next three consecutive cycles, by exactly three writes with `mem_we_o` = 1. The first writes the snapshot PC bits [7:0], the second writes PC bits [15:8], and the third writes the status byte.
- R3: Each write goes to address 0x0100 | SP, using the pointer value in that cycle. After each write, SP decreases by one modulo 256, so 0x00 is followed by 0xFF. SP never changes without a write.
- R4: The status byte on the stack equals the snapshot status with bit 4 (the break bit) forced to 1. Every other bit is unchanged, including bit 2 (interrupt-disable).
- R5: In the cycle after the fourth busy cycle, `pc_o` equals the snapshot vector and `flags_o` equals the snapshot status with bit 2 set. Before that, both keep their earlier values.
- R6: `busy_o` is 1 for exactly four cycles per entry: the three write cycles and one load cycle. `mem_we_o` is 0 whenever no frame byte is being written.
- R7: A trigger raised while `busy_o` is 1 is ignored. The PC, status and vector inputs matter only in the cycle a trigger is taken, so changing them during an entry has no effect on it.
- R8: After each complete entry, SP equals its value before the entry minus 3, modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Request to start a break entry |
| pc_i | input | 16 | Current program counter, sampled when a trigger is taken |
| flags_i | input | 8 | Current status byte, sampled when a trigger is taken |
| vector_i | input | 16 | Handler address, sampled when a trigger is taken |
| mem_we_o | output | 1 | Stack write strobe |
| mem_addr_o | output | 16 | Stack write address |
| mem_wdata_o | output | 8 | Stack write data |
| busy_o | output | 1 | Entry sequence in progress |
| sp_o | output | 8 | Stack pointer |
| pc_o | output | 16 | Program counter result |
| flags_o | output | 8 | Status result |

## Verification
The bench runs enough entries to carry the stack pointer through 0x00 and back to 0xFF. A design that did not wrap, or that carried into the page byte, would put a write outside page one. Some entries raise the trigger again during the write and load cycles, with different PC, status and vector values on the inputs. A design that restarted, or that read its inputs live, would write extra bytes, lose the return address or jump to the wrong vector. Status values with bit 2 both set and clear show whether interrupt-disable leaks into the stacked copy or the break bit leaks into the live flags.

// File: rtl/brk_seq_pkg.sv
// Package: brk_seq_pkg
// Holds the types and fixed sizes that the sequencer modules share.
// Assumes a byte-wide data path and a 16-bit address space.
package brk_seq_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int FRAME_LEN = 3;
    localparam int SLOT_W    = $clog2(FRAME_LEN);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PUSH0 = 3'd1,
        ST_PUSH1 = 3'd2,
        ST_PUSH2 = 3'd3,
        ST_LOAD  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/brk_seq_fsm.sv
// Module: brk_seq_fsm
// Sequencer control. From idle, it accepts a trigger and then steps through
// three write states and one load state, one state per cycle.
// Assumes the trigger is a level that is sampled only in idle.
module brk_seq_fsm
    import brk_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    output logic              accept_o,
    output logic              push_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              load_o,
    output logic              busy_o
);

    seq_state_t state_q;
    seq_state_t state_d;

    // Next-state decode for the entry sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (trig_i) state_d = ST_PUSH0;
            ST_PUSH0: state_d = ST_PUSH1;
            ST_PUSH1: state_d = ST_PUSH2;
            ST_PUSH2: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode: write slot, load strobe and busy level
    always_comb begin
        push_o = 1'b0;
        slot_o = '0;
        load_o = 1'b0;
        unique case (state_q)
            ST_PUSH0: begin push_o = 1'b1; slot_o = SLOT_W'(0); end
            ST_PUSH1: begin push_o = 1'b1; slot_o = SLOT_W'(1); end
            ST_PUSH2: begin push_o = 1'b1; slot_o = SLOT_W'(2); end
            ST_LOAD:  load_o = 1'b1;
            default:  ;
        endcase
    end

    assign accept_o = (state_q == ST_IDLE) && trig_i;
    assign busy_o   = (state_q != ST_IDLE);

endmodule

// File: rtl/brk_seq_sp.sv
// Module: brk_seq_sp
// Stack pointer register. It moves down by one after each frame write and
// wraps modulo 256. The page prefix is added elsewhere.
// Assumes at most one decrement per cycle.
module brk_seq_sp
    import brk_seq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SP_RESET = 8'hFF
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_i,
    output logic [BYTE_W-1:0] sp_o
);

    logic [BYTE_W-1:0] sp_q;

    // Pointer register: reset to top of stack, step down after each write
    always_ff @(posedge clk) begin
        if (!rst_n)     sp_q <= SP_RESET;
        else if (dec_i) sp_q <= sp_q - BYTE_W'(1);
    end

    assign sp_o = sp_q;

endmodule

// File: rtl/brk_seq_frame.sv
// Module: brk_seq_frame
// Captures PC, status and vector when a trigger is taken. Builds the
// three-byte return frame and selects the byte for the current write slot.
// Assumes slot values 0..FRAME_LEN-1, with slot 0 written first.
module brk_seq_frame
    import brk_seq_pkg::*;
#(
    parameter int BRK_BIT = 4
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [BYTE_W-1:0] flags_i,
    input  logic [ADDR_W-1:0] vector_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic [ADDR_W-1:0] cap_vector_o,
    output logic [BYTE_W-1:0] cap_flags_o
);

    localparam logic [BYTE_W-1:0] BRK_MASK = BYTE_W'(1) << BRK_BIT;

    logic [ADDR_W-1:0] cap_pc_q;
    logic [BYTE_W-1:0] cap_flags_q;
    logic [ADDR_W-1:0] cap_vec_q;
    logic [BYTE_W-1:0] frame [FRAME_LEN];

    // Snapshot registers, loaded only when a trigger is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_pc_q    <= '0;
            cap_flags_q <= '0;
            cap_vec_q   <= '0;
        end else if (accept_i) begin
            cap_pc_q    <= pc_i;
            cap_flags_q <= flags_i;
            cap_vec_q   <= vector_i;
        end
    end

    // Frame layout: return address bytes low first, then the marked status
    genvar k;
    generate
        for (k = 0; k < FRAME_LEN; k++) begin : g_frame
            if (k == FRAME_LEN - 1) begin : g_status
                assign frame[k] = cap_flags_q | BRK_MASK;
            end else begin : g_pc
                assign frame[k] = cap_pc_q[k*BYTE_W +: BYTE_W];
            end
        end
    endgenerate

    // Slot select for the byte being written this cycle
    always_comb begin
        byte_o = '0;
        for (int i = 0; i < FRAME_LEN; i++) begin
            if (slot_i == SLOT_W'(i)) byte_o = frame[i];
        end
    end

    assign cap_vector_o = cap_vec_q;
    assign cap_flags_o  = cap_flags_q;

endmodule

// File: rtl/brk_seq_result.sv
// Module: brk_seq_result
// Architectural result registers. In the load step the program counter takes
// the captured vector and the status takes the captured flags with
// interrupt-disable set.
// Assumes exactly one load strobe per entry.
module brk_seq_result
    import brk_seq_pkg::*;
#(
    parameter int IDIS_BIT = 2
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] vector_i,
    input  logic [BYTE_W-1:0] flags_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [BYTE_W-1:0] flags_o
);

    localparam logic [BYTE_W-1:0] IDIS_MASK = BYTE_W'(1) << IDIS_BIT;

    logic [ADDR_W-1:0] pc_q;
    logic [BYTE_W-1:0] flags_q;

    // Result registers, updated once at the end of the sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            flags_q <= '0;
        end else if (load_i) begin
            pc_q    <= vector_i;
            flags_q <= flags_i | IDIS_MASK;
        end
    end

    assign pc_o    = pc_q;
    assign flags_o = flags_q;

endmodule

// File: rtl/brk_entry_seq.sv
// Module: brk_entry_seq
// Top level of the software break entry sequencer. It connects the control
// FSM, the stack pointer, the frame builder and the result registers, and
// forms page-one stack addresses.
// Assumes the memory accepts one byte write per cycle with no stall.
module brk_entry_seq
    import brk_seq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SP_RESET   = 8'hFF,
    parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01,
    parameter int                BRK_BIT    = 4,
    parameter int                IDIS_BIT   = 2
)
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_i,
    input  logic [15:0] pc_i,
    input  logic [7:0]  flags_i,
    input  logic [15:0] vector_i,
    output logic        mem_we_o,
    output logic [15:0] mem_addr_o,
    output logic [7:0]  mem_wdata_o,
    output logic        busy_o,
    output logic [7:0]  sp_o,
    output logic [15:0] pc_o,
    output logic [7:0]  flags_o
);

    logic              accept;
    logic              push;
    logic [SLOT_W-1:0] slot;
    logic              load;
    logic [ADDR_W-1:0] cap_vector;
    logic [BYTE_W-1:0] cap_flags;
    logic [BYTE_W-1:0] sp;

    brk_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_i),
        .accept_o (accept),
        .push_o   (push),
        .slot_o   (slot),
        .load_o   (load),
        .busy_o   (busy_o)
    );

    brk_seq_sp #(.SP_RESET(SP_RESET)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec_i (push),
        .sp_o  (sp)
    );

    brk_seq_frame #(.BRK_BIT(BRK_BIT)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .pc_i         (pc_i),
        .flags_i      (flags_i),
        .vector_i     (vector_i),
        .slot_i       (slot),
        .byte_o       (mem_wdata_o),
        .cap_vector_o (cap_vector),
        .cap_flags_o  (cap_flags)
    );

    brk_seq_result #(.IDIS_BIT(IDIS_BIT)) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .vector_i (cap_vector),
        .flags_i  (cap_flags),
        .pc_o     (pc_o),
        .flags_o  (flags_o)
    );

    assign mem_we_o   = push;
    assign mem_addr_o = {STACK_PAGE, sp};
    assign sp_o       = sp;

endmodule

// File: rtl/brk_seq_chk.sv
// Module: brk_seq_chk
// Checker for the break entry sequencer, attached to the top through bind.
// It watches only top-level ports.
module brk_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        trig_i,
    input logic        mem_we_o,
    input logic [15:0] mem_addr_o,
    input logic [7:0]  mem_wdata_o,
    input logic        busy_o,
    input logic [7:0]  sp_o,
    input logic [7:0]  flags_o
);

    assert_write_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |=> mem_we_o ##1 mem_we_o ##1 (!mem_we_o && busy_o));

    assert_page_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o[15:8] == 8'h01 && mem_addr_o[7:0] == sp_o));

    assert_sp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_we_o) |-> (sp_o == $past(sp_o) - 8'd1));

    assert_sp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_we_o) |-> $stable(sp_o));

    assert_brk_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_we_o, 2) && $past(mem_we_o) && mem_we_o) |-> mem_wdata_o[4]);

    assert_idis_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> flags_o[2]);

    assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !trig_i) |=> !busy_o);

endmodule

bind brk_entry_seq brk_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (busy_o),
    .sp_o        (sp_o),
    .flags_o     (flags_o)
);

// File: tb/sim_brk_entry_seq.sv
module sim_brk_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [7:0]  flags_i = '0;
    logic [15:0] vector_i = '0;
    logic        mem_we_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        busy_o;
    logic [7:0]  sp_o;
    logic [15:0] pc_o;
    logic [7:0]  flags_o;

    int checks = 0;
    int errors = 0;
    logic [7:0]  exp_sp = 8'hFF;
    logic [15:0] exp_pc = 16'h0000;
    logic [7:0]  exp_fl = 8'h00;

    always #2.5 clk = ~clk;

    brk_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .pc_i(pc_i),
        .flags_i(flags_i), .vector_i(vector_i), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .busy_o(busy_o),
        .sp_o(sp_o), .pc_o(pc_o), .flags_o(flags_o)
    );

    function automatic logic [7:0] stacked_status(input logic [7:0] f);
        return f | 8'h10;
    endfunction

    function automatic logic [7:0] live_status(input logic [7:0] f);
        return f | 8'h04;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One entry; glitch raises the trigger again with other data while busy
    task automatic run_entry(input logic [15:0] pc, input logic [7:0] fl,
                             input logic [15:0] vec, input bit glitch);
        logic [7:0] sp0;
        sp0 = exp_sp;
        @(negedge clk);
        trig_i = 1'b1; pc_i = pc; flags_i = fl; vector_i = vec;
        @(negedge clk);
        trig_i = glitch;
        if (glitch) begin pc_i = ~pc; flags_i = ~fl; vector_i = ~vec; end
        // first write: PC low (R2, R3)
        chk(mem_we_o === 1'b1, "R2 we0", 32'(mem_we_o), 1);
        chk(mem_addr_o === {8'h01, sp0}, "R3 addr0", 32'(mem_addr_o), 32'({8'h01, sp0}));
        chk(mem_wdata_o === pc[7:0], "R2 pc low", 32'(mem_wdata_o), 32'(pc[7:0]));
        chk(busy_o === 1'b1, "R6 busy0", 32'(busy_o), 1);
        chk(pc_o === exp_pc, "R5 pc held", 32'(pc_o), 32'(exp_pc));
        @(negedge clk);
        chk(mem_we_o === 1'b1, "R2 we1", 32'(mem_we_o), 1);
        chk(mem_addr_o === {8'h01, 8'(sp0 - 8'd1)}, "R3 addr1", 32'(mem_addr_o),
            32'({8'h01, 8'(sp0 - 8'd1)}));
        chk(mem_wdata_o === pc[15:8], "R2 pc high", 32'(mem_wdata_o), 32'(pc[15:8]));
        @(negedge clk);
        chk(mem_we_o === 1'b1, "R2 we2", 32'(mem_we_o), 1);
        chk(mem_addr_o === {8'h01, 8'(sp0 - 8'd2)}, "R3 addr2", 32'(mem_addr_o),
            32'({8'h01, 8'(sp0 - 8'd2)}));
        chk(mem_wdata_o === stacked_status(fl), "R4 status", 32'(mem_wdata_o),
            32'(stacked_status(fl)));
        @(negedge clk);
        chk(mem_we_o === 1'b0 && busy_o === 1'b1, "R6 load cycle",
            32'({mem_we_o, busy_o}), 32'b01);
        chk(flags_o === exp_fl, "R5 flags held", 32'(flags_o), 32'(exp_fl));
        @(negedge clk);
        trig_i = 1'b0;
        exp_sp = sp0 - 8'd3;
        exp_pc = vec;
        exp_fl = live_status(fl);
        chk(busy_o === 1'b0 && mem_we_o === 1'b0, "R6 idle after",
            32'({busy_o, mem_we_o}), 0);
        chk(pc_o === exp_pc, "R5 pc vector", 32'(pc_o), 32'(exp_pc));
        chk(flags_o === exp_fl, "R5 flags idis", 32'(flags_o), 32'(exp_fl));
        chk(sp_o === exp_sp, "R8 sp minus three", 32'(sp_o), 32'(exp_sp));
        if (glitch) begin
            @(negedge clk);
            chk(busy_o === 1'b0 && sp_o === exp_sp && pc_o === exp_pc,
                "R7 busy trigger ignored", 32'({busy_o, sp_o}), 32'({1'b0, exp_sp}));
        end
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(sp_o === 8'hFF, "R1 sp reset", 32'(sp_o), 32'hFF);
        chk(pc_o === 16'h0 && flags_o === 8'h0, "R1 pc/flags reset",
            32'({pc_o, flags_o}), 0);
        chk(busy_o === 1'b0 && mem_we_o === 1'b0, "R1 idle reset",
            32'({busy_o, mem_we_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o === 1'b0 && sp_o === 8'hFF, "R7 no trigger stays idle",
            32'({busy_o, sp_o}), 32'({1'b0, 8'hFF}));
        // directed corners
        run_entry(16'h1234, 8'h00, 16'hFFFE, 1'b0);
        run_entry(16'hABCD, 8'h04, 16'h8000, 1'b1);
        run_entry(16'h00FF, 8'hFF, 16'h0000, 1'b0);
        run_entry(16'hFF00, 8'hEB, 16'h1357, 1'b1);
        // random entries, enough to wrap SP past 0x00 (R3, R8)
        for (int n = 0; n < 90; n++) begin
            run_entry(16'($urandom), 8'($urandom), 16'($urandom), 1'($urandom));
        end
        // reset in the middle of an entry (R1)
        @(negedge clk);
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(sp_o === 8'hFF && busy_o === 1'b0 && pc_o === 16'h0,
            "R1 reset mid entry", 32'({sp_o, busy_o}), 32'({8'hFF, 1'b0}));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule